// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Sequencer

This block is the control core of a small stored-program processor. It walks each instruction through fetch, decode, effective-address evaluation, operand fetch, execute and result store, one machine cycle per clock. It holds the program counter, the memory address and data registers and the instruction register. It reaches a word-addressed memory through a request/ready handshake, so any access may take as many cycles as the memory needs.

An external decode function looks at the instruction register and returns a two-bit class. The sequencer uses that class to skip the phases an instruction does not need. It drives operand-read, ALU and register-write strobes to the datapath. A control-class instruction replaces the program counter during execute. Every other instruction continues from the address after its own. A halt input freezes the whole machine in place, and releasing halt resumes from the same point.

Top module: `icycle_seq`

## Requirements
- R1: When rst_ni is low, pc_o, ir_o, mem_addr_o and mdr_o are zero and no strobe is active. The first memory read after reset fetches address 0.
- R2: Fetch proceeds in order: the address register takes the PC, then the PC adds one, then the word is read, then the IR loads. During the fetch read, mem_addr_o equals the expected PC and pc_o equals that address plus one.
- R3: The IR holds the fetched word from the cycle after the fetch read until the next fetch read completes.
- R4: A memory read (mem_re_o) holds until mem_ready_i is sampled high. The data read then appears on mdr_o in the next cycle.
- R5: Class 0 (register operate) skips address evaluation. It does one operand-register read (opnd_ld_o), one ALU cycle (alu_en_o) and then one register write with rf_wsel_o=0 (ALU result). The body after decode takes 3 cycles.
- R6: Class 1 (load) loads the address register from ea_i and reads memory there. It skips execute and then writes the register file with rf_wsel_o=1, with the read word on mdr_o. The body takes 3 cycles plus memory wait cycles.
- R7: Class 2 (store) loads the address register from ea_i and copies rf_rdata_i into the data register during the operand step. It skips execute and then writes memory at ea_i. It never raises alu_en_o or rf_we_o.
- R8: Class 3 (control) loads the address register from ea_i and does one execute cycle that writes that address into the PC. The next fetch reads from ea_i. It does no register write and no data access. The body takes 2 cycles.
- R9: During a memory write, mem_wdata_o already carries the store value in the first cycle of mem_we_o. The address and data then stay stable until ready.
- R10: While halt_i is high, every strobe is low. PC, IR, the address register and the data register keep their values across the next edge. Releasing halt resumes the sequence.
- R11: With no halt, the number of cycles from one completed fetch read to the next is 5 plus the body length plus all memory wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Freeze the machine while high |
| mem_addr_o | output | ADDR_W | Memory address (address register) |
| mem_wdata_o | output | DATA_W | Memory write data (data register) |
| mem_we_o | output | 1 | Memory write request |
| mem_re_o | output | 1 | Memory read request |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_ready_i | input | 1 | Memory completes the current request |
| ir_o | output | DATA_W | Instruction register, to the decode function |
| class_i | input | 2 | Instruction class: 0 operate, 1 load, 2 store, 3 control |
| ea_i | input | ADDR_W | Effective address from the datapath |
| pc_o | output | ADDR_W | Program counter |
| mdr_o | output | DATA_W | Data register, register-file write source |
| opnd_ld_o | output | 1 | Operand-register read strobe |
| rf_rdata_i | input | DATA_W | Register-file read data for stores |
| alu_en_o | output | 1 | ALU execute strobe |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wsel_o | output | 1 | Register write source: 0 ALU, 1 data register |

## Verification
The fetch read request appears two cycles after the previous instruction ends. The IR holds the fetched word two edges after ready. A loaded word is visible on mdr_o in the cycle after the read completes, which is the same cycle in which rf_we_o is raised. The bench samples every port at the falling edge and tracks each instruction's strobes from one completed fetch read to the next. It counts the edges between consecutive fetch reads and compares that count with 5 plus the class body length plus the wait cycles it inserted itself. Any interval that contains a halt is left out of that timing check, and the halt interval is checked for frozen state instead.

// File: rtl/icycle_seq_pkg.sv
package icycle_seq_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [3:0] {
    ST_FMAR, ST_FINC, ST_FRD, ST_FIR, ST_DEC, ST_EVAL,
    ST_OPREG, ST_OPMEM, ST_EXEC, ST_WBREG, ST_WBMEM
  } state_e;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU = 2'd0, CL_LOAD = 2'd1, CL_STORE = 2'd2, CL_JUMP = 2'd3
  } iclass_e;

  typedef struct packed {
    logic mar_pc;
    logic mar_ea;
    logic pc_inc;
    logic pc_jmp;
    logic mdr_mem;
    logic mdr_reg;
    logic ir_ld;
  } reg_ctl_t;
endpackage

// File: rtl/icycle_seq_fsm.sv
module icycle_seq_fsm
  import icycle_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             mem_ready_i,
  input  logic [CLS_W-1:0] class_i,
  output reg_ctl_t         ctl_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic             opnd_ld_o,
  output logic             alu_en_o,
  output logic             rf_we_o,
  output logic             rf_wsel_o
);
  state_e  state_q, state_d;
  iclass_e cls_q;
  reg_ctl_t ctl;
  logic re, we, opnd, alu, rfw;

  always_comb begin
    state_d = state_q;
    ctl  = '0;
    re   = 1'b0;
    we   = 1'b0;
    opnd = 1'b0;
    alu  = 1'b0;
    rfw  = 1'b0;
    unique case (state_q)
      ST_FMAR: begin ctl.mar_pc = 1'b1; state_d = ST_FINC; end
      ST_FINC: begin ctl.pc_inc = 1'b1; state_d = ST_FRD; end
      ST_FRD: begin
        re = 1'b1;
        if (mem_ready_i) begin ctl.mdr_mem = 1'b1; state_d = ST_FIR; end
      end
      ST_FIR: begin ctl.ir_ld = 1'b1; state_d = ST_DEC; end
      ST_DEC: state_d = (iclass_e'(class_i) == CL_ALU) ? ST_OPREG : ST_EVAL;
      ST_EVAL: begin
        ctl.mar_ea = 1'b1;
        unique case (cls_q)
          CL_LOAD:  state_d = ST_OPMEM;
          CL_STORE: state_d = ST_OPREG;
          default:  state_d = ST_EXEC;
        endcase
      end
      ST_OPREG: begin
        opnd = 1'b1;
        if (cls_q == CL_STORE) begin ctl.mdr_reg = 1'b1; state_d = ST_WBMEM; end
        else state_d = ST_EXEC;
      end
      ST_OPMEM: begin
        re = 1'b1;
        if (mem_ready_i) begin ctl.mdr_mem = 1'b1; state_d = ST_WBREG; end
      end
      ST_EXEC: begin
        alu = 1'b1;
        if (cls_q == CL_JUMP) begin ctl.pc_jmp = 1'b1; state_d = ST_FMAR; end
        else state_d = ST_WBREG;
      end
      ST_WBREG: begin rfw = 1'b1; state_d = ST_FMAR; end
      ST_WBMEM: begin
        we = 1'b1;
        if (mem_ready_i) state_d = ST_FMAR;
      end
      default: state_d = ST_FMAR;
    endcase
    // halt freezes everything at the coming edge
    if (halt_i) begin
      state_d = state_q;
      ctl  = '0;
      re   = 1'b0;
      we   = 1'b0;
      opnd = 1'b0;
      alu  = 1'b0;
      rfw  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FMAR;
      cls_q   <= CL_ALU;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DEC && !halt_i) cls_q <= iclass_e'(class_i);
    end
  end

  assign ctl_o     = ctl;
  assign mem_re_o  = re;
  assign mem_we_o  = we;
  assign opnd_ld_o = opnd;
  assign alu_en_o  = alu;
  assign rf_we_o   = rfw;
  assign rf_wsel_o = (cls_q == CL_LOAD);
endmodule

// File: rtl/icycle_seq_regs.sv
module icycle_seq_regs
  import icycle_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_ctl_t          ctl_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [DATA_W-1:0] ir_o
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ctl_i.pc_inc)      pc_q <= pc_q + PC_STEP;
      else if (ctl_i.pc_jmp) pc_q <= mar_q;  // jump target was staged in MAR
      if (ctl_i.mar_pc)      mar_q <= pc_q;
      else if (ctl_i.mar_ea) mar_q <= ea_i;
      if (ctl_i.mdr_mem)      mdr_q <= mem_rdata_i;
      else if (ctl_i.mdr_reg) mdr_q <= rf_rdata_i;
      if (ctl_i.ir_ld) ir_q <= mdr_q;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign ir_o  = ir_q;
endmodule

// File: rtl/icycle_seq.sv
module icycle_seq
  import icycle_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [DATA_W-1:0] ir_o,
  input  logic [1:0]        class_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic              opnd_ld_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              alu_en_o,
  output logic              rf_we_o,
  output logic              rf_wsel_o
);
  reg_ctl_t          ctl;
  logic [DATA_W-1:0] mdr;

  icycle_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (halt_i),
    .mem_ready_i (mem_ready_i),
    .class_i     (class_i),
    .ctl_o       (ctl),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .opnd_ld_o   (opnd_ld_o),
    .alu_en_o    (alu_en_o),
    .rf_we_o     (rf_we_o),
    .rf_wsel_o   (rf_wsel_o)
  );

  icycle_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .ea_i        (ea_i),
    .mem_rdata_i (mem_rdata_i),
    .rf_rdata_i  (rf_rdata_i),
    .pc_o        (pc_o),
    .mar_o       (mem_addr_o),
    .mdr_o       (mdr),
    .ir_o        (ir_o)
  );

  assign mdr_o       = mdr;
  assign mem_wdata_o = mdr;
endmodule

// File: rtl/icycle_seq_chk.sv
module icycle_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              mem_ready_i,
  input logic [DATA_W-1:0] ir_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              opnd_ld_o,
  input logic              alu_en_o,
  input logic              rf_we_o
);
  assert_strobe_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_re_o, mem_we_o, opnd_ld_o, alu_en_o, rf_we_o}));

  assert_halt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !(mem_re_o || mem_we_o || opnd_ld_o || alu_en_o || rf_we_o));

  assert_halt_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> ($stable(pc_o) && $stable(ir_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + ADDR_W'(1) || pc_o == $past(mem_addr_o)));

  assert_wr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_ready_i) |=> ($stable(mem_wdata_o) && $stable(mem_addr_o)));

  assert_wb_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);
endmodule

bind icycle_seq icycle_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_i      (halt_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_ready_i (mem_ready_i),
  .ir_o        (ir_o),
  .pc_o        (pc_o),
  .opnd_ld_o   (opnd_ld_o),
  .alu_en_o    (alu_en_o),
  .rf_we_o     (rf_we_o)
);

// File: tb/icycle_seq_bench.sv
`timescale 1ns/1ps
module icycle_seq_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NCYC = 30000;

  logic clk = 1'b0;
  logic rst_ni, halt_i, ready;
  logic [AW-1:0] mem_addr, pc, ea;
  logic [DW-1:0] wdata, rdata, ir, mdr, rf_rdata;
  logic we, re, opnd, alu, rfw, wsel;
  logic [1:0] cls_in;
  logic [DW-1:0] mem [256];

  always #5 clk = ~clk;

  // bench-side decode function and datapath stand-ins
  assign cls_in   = ir[15:14];
  assign ea       = {8'h00, ir[7:0]};
  assign rf_rdata = ir ^ 16'h5a5a;
  assign rdata    = mem[mem_addr[7:0]];

  icycle_seq u_icycle_seq (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt_i),
    .mem_addr_o(mem_addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
    .mem_rdata_i(rdata), .mem_ready_i(ready), .ir_o(ir), .class_i(cls_in),
    .ea_i(ea), .pc_o(pc), .mdr_o(mdr), .opnd_ld_o(opnd), .rf_rdata_i(rf_rdata),
    .alu_en_o(alu), .rf_we_o(rfw), .rf_wsel_o(wsel)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int body_len(input logic [1:0] c);
    return (c == 2'd3) ? 2 : 3;
  endfunction

  function automatic logic [4:0] exp_counts(input logic [1:0] c);
    // {opnd, alu, rf_we, operand read, write}
    case (c)
      2'd0: return 5'b11100;
      2'd1: return 5'b00110;
      2'd2: return 5'b10001;
      default: return 5'b01000;
    endcase
  endfunction

  initial begin
    logic [AW-1:0] exp_pc;
    logic [DW-1:0] instr, ld_val, snap_pc, snap_ir, snap_addr, snap_wd;
    logic [1:0] cur_cls;
    logic [AW-1:0] cur_ea;
    bit in_fetch, have_prev, prev_halt, halt_seen;
    int n_op, n_alu, n_rf, n_rd, n_we, cnt, waits, wcnt, lat;

    void'($urandom(32'h1c5e));
    for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
    mem[0]  = 16'h0012;          // operate
    mem[1]  = 16'h4040;          // load from 0x40
    mem[2]  = 16'h8041;          // store to 0x41
    mem[3]  = 16'hc010;          // jump to 0x10
    mem[16] = 16'h0033;          // operate
    mem[17] = 16'hc000;          // jump to 0

    rst_ni = 1'b0; halt_i = 1'b0; ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc == 0 && ir == 0 && mem_addr == 0 && mdr == 0, "R1 reset regs", {pc, ir}, 32'h0);
    chk({re, we, opnd, alu, rfw} == 5'b0, "R1 reset strobes", {27'h0, re, we, opnd, alu, rfw}, 32'h0);
    rst_ni = 1'b1;

    exp_pc = '0; instr = '0; ld_val = '0; cur_cls = '0; cur_ea = '0;
    snap_pc = '0; snap_ir = '0; snap_addr = '0; snap_wd = '0;
    in_fetch = 1'b1; have_prev = 1'b0; prev_halt = 1'b0; halt_seen = 1'b0;
    n_op = 0; n_alu = 0; n_rf = 0; n_rd = 0; n_we = 0; cnt = 0; waits = 0; wcnt = 0; lat = 0;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      cnt++;
      if (cyc >= 5000 && cyc < 5020) halt_i = 1'b1;
      else halt_i = ($urandom % 32) == 0;
      #1;
      if (prev_halt)
        chk(pc == snap_pc && ir == snap_ir && mem_addr == snap_addr && wdata == snap_wd,
            "R10 frozen across halt", {pc, ir}, {snap_pc, snap_ir});
      if (halt_i) begin
        chk({re, we, opnd, alu, rfw} == 5'b0, "R10 strobes low in halt",
            {27'h0, re, we, opnd, alu, rfw}, 32'h0);
        snap_pc = pc; snap_ir = ir; snap_addr = mem_addr; snap_wd = wdata;
        halt_seen = 1'b1;
      end
      prev_halt = halt_i;

      if (re || we) begin
        ready = (wcnt == lat);
        if (!ready) waits++;
        wcnt++;
      end else begin
        ready = 1'b0;
        wcnt = 0;
        lat = $urandom % 6;
        if (lat > 3) lat = 0;
      end
      #1;

      if (re && ready) begin
        if (in_fetch) begin
          if (have_prev) begin
            chk(ir == instr, "R3 IR held until next fetch", ir, instr);
            chk({n_op[0], n_alu[0], n_rf[0], n_rd[0], n_we[0]} == exp_counts(cur_cls)
                && n_op < 2 && n_alu < 2 && n_rf < 2 && n_rd < 2 && n_we < 2,
                (cur_cls == 0) ? "R5 operate phases" : (cur_cls == 1) ? "R6 load phases" :
                (cur_cls == 2) ? "R7 store phases" : "R8 control phases",
                {n_op[3:0], n_alu[3:0], n_rf[3:0], n_rd[3:0], n_we[3:0]}, {15'h0, exp_counts(cur_cls)});
            if (!halt_seen)
              chk(cnt == 5 + body_len(cur_cls) + waits, "R11 instruction cycle count",
                  cnt, 5 + body_len(cur_cls) + waits);
          end
          chk(mem_addr == exp_pc, have_prev ? "R2 fetch address" : "R1 first fetch at 0", mem_addr, exp_pc);
          chk(pc == mem_addr + 1, "R2 PC incremented before read", pc, mem_addr + 1);
          instr = mem[mem_addr[7:0]];
          cur_cls = instr[15:14];
          cur_ea = {8'h00, instr[7:0]};
          exp_pc = mem_addr + 1;
          have_prev = 1'b1; in_fetch = 1'b0; halt_seen = 1'b0;
          n_op = 0; n_alu = 0; n_rf = 0; n_rd = 0; n_we = 0; cnt = 0; waits = 0;
        end else begin
          n_rd++;
          chk(mem_addr == cur_ea, "R6 load address", mem_addr, cur_ea);
          chk(ir == instr, "R3 IR during body", ir, instr);
          ld_val = mem[mem_addr[7:0]];
        end
      end

      if (we) begin
        chk(wdata == (instr ^ 16'h5a5a), "R9 write data ready with write enable", wdata, instr ^ 16'h5a5a);
        chk(mem_addr == cur_ea, "R7 store address", mem_addr, cur_ea);
        if (ready) begin
          n_we++;
          mem[mem_addr[7:0]] = wdata;
          in_fetch = 1'b1;
        end
      end

      if (opnd) n_op++;

      if (alu) begin
        n_alu++;
        if (cur_cls == 2'd3) begin
          exp_pc = cur_ea;
          in_fetch = 1'b1;
        end
      end

      if (rfw) begin
        n_rf++;
        chk(wsel == (cur_cls == 2'd1), "R5 R6 write source select", wsel, cur_cls == 2'd1);
        if (cur_cls == 2'd1)
          chk(mdr == ld_val, "R4 R6 loaded word on mdr_o", mdr, ld_val);
        in_fetch = 1'b1;
      end

      if (cnt > 400) begin
        chk(1'b0, "R11 watchdog", cnt, 400);
        break;
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule